// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the bus side of a 16-bit parallel NOR flash model. Each write cycle carries a word address and a data word. The block follows the multi-write command sequences of the classic unlock-style command set. It decides what a read returns: the stored array, the identification words, or the query signature. It programs single words of a small internal array. Erase requests are passed to a separate erase controller.

The sequencer is a named state machine with these states:

- `S_IDLE`: waiting for the first write of a sequence.
- `S_UNLK1`: the first unlock write has been accepted.
- `S_UNLK2`: the second unlock write has been accepted, and the next write chooses the command.
- `S_PROG`: a program is armed, and the next write supplies its data.
- `S_ESET`: erase setup.
- `S_EUNLK1` and `S_EUNLK2`: the two repeated unlock writes of an erase.

Its transitions are:

- unlock-first (`S_IDLE`→`S_UNLK1`)
- unlock-second (`S_UNLK1`→`S_UNLK2`)
- select-id, select-program, select-erase and select-bypass (all leaving `S_UNLK2`)
- bypass-arm (`S_IDLE`→`S_PROG` while bypass is on)
- program-data (`S_PROG`→`S_IDLE`)
- erase-unlock-first (`S_ESET`→`S_EUNLK1`)
- erase-unlock-second (`S_EUNLK1`→`S_EUNLK2`)
- erase-issue (`S_EUNLK2`→`S_IDLE`)
- abort (any mismatch →`S_IDLE`)

The read mode is one of three values: array, identification, or query. Beside the read mode there is one saved mode, so that leaving the query view returns to the view it was entered from.

A host drives `wr_en` for one clock with the address and data of each write. State, mode and array changes take effect at that clock edge. `rd_data` is a combinational function of `rd_addr` and the registered state, so a read is valid in the cycle after a write. An erase request appears on `erase_req` for exactly one clock after the final write of an erase sequence.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset the read mode is array, bypass is off, every array word reads 0xFFFF, `erase_req` is 0, and any partly entered sequence is forgotten.
- R2: The writes 0xAA at word 0x555, then 0x55 at 0x2AA, then 0x90 at 0x555 enter identification mode. In that mode, address 0 reads 0x00BF, address 1 reads 0x236D, and other addresses read 0x0000.
- R3: Command addresses are compared on their low 11 bits only, so 0x5555 and 0x2AAA act as the unlock addresses.
- R4: A program is the writes 0xAA at 0x555, then 0x55 at 0x2AA, then 0xA0 at 0x555, then the data word at the target address. It can only clear bits: 0x0055 followed by 0x00A5 on an erased word leaves 0x0005.
- R5: The unlock writes followed by 0x20 at 0x555 enter bypass mode. In bypass mode, 0xA0 at any address followed by a data write programs one word without unlock writes.
- R6: A write of 0x00 while in bypass mode leaves bypass mode. After that, an 0xA0 write followed by a data write changes nothing.
- R7: A write of 0x98 at word 0x55 while in array or identification mode enters query mode. In query mode, addresses 0x10, 0x11 and 0x12 read 0x0051, 0x0052 and 0x0059.
- R8: A write of 0xF0 at any address, outside bypass mode, leaves query mode for the mode that query mode was entered from. In any other mode it returns to array mode.
- R9: A write that does not match the expected next write of a sequence ends the sequence. It leaves the read mode as it was and does not change the array.
- R10: The unlock writes, 0x80 at 0x555, the unlock writes again, and then 0x30 at any address raise `erase_req` with `erase_chip` low and `erase_addr` equal to the address of the last write.
- R11: The same sequence ending in 0x10 at 0x555 raises `erase_req` with `erase_chip` high.
- R12: `erase_req` is high for one clock only, and only after a complete erase sequence. A wrong final write raises no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One bus write in this cycle |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 16 | Data word of the write |
| rd_addr | input | ADDR_W | Word address being read |
| rd_data | output | 16 | Read result in the current mode |
| erase_req | output | 1 | One-cycle erase request |
| erase_chip | output | 1 | Request is a whole-chip erase |
| erase_addr | output | ADDR_W | Address of the sector erase write |

## Verification
The hardest states to reach are the stacked ones. One is query mode entered from identification mode, where a reset must land back in identification mode rather than in array mode. The other is a sequence aborted while identification mode is active. Both are reached only through an exact chain of address-qualified writes. The vector walk therefore builds each chain in order, reads the signature or identification words at each step, and breaks a chain on purpose in mid-flight. Directed tests then apply reset in the middle of an unlock chain and during bypass mode. They also cover both erase endings and a wrong erase ending.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_UNLK1,
        S_UNLK2,
        S_PROG,
        S_ESET,
        S_EUNLK1,
        S_EUNLK2
    } seq_state_t;

    typedef enum logic [1:0] {
        RM_ARRAY,
        RM_ID,
        RM_QUERY
    } read_mode_t;

    localparam logic [7:0] C_UNLK_A   = 8'hAA;
    localparam logic [7:0] C_UNLK_B   = 8'h55;
    localparam logic [7:0] C_ID       = 8'h90;
    localparam logic [7:0] C_PROG     = 8'hA0;
    localparam logic [7:0] C_ERASE    = 8'h80;
    localparam logic [7:0] C_BYPASS   = 8'h20;
    localparam logic [7:0] C_BYP_EXIT = 8'h00;
    localparam logic [7:0] C_RESET    = 8'hF0;
    localparam logic [7:0] C_QUERY    = 8'h98;
    localparam logic [7:0] C_SECTOR   = 8'h30;
    localparam logic [7:0] C_CHIP     = 8'h10;

    localparam logic [15:0] ID_MAKER  = 16'h00BF;
    localparam logic [15:0] ID_DEVICE = 16'h236D;

endpackage

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int CMD_BITS = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_cmd,
    output read_mode_t        read_mode,
    output logic              bypass,
    output logic              prog_we,
    output logic              erase_req,
    output logic              erase_chip,
    output logic [ADDR_W-1:0] erase_addr
);

    localparam logic [CMD_BITS-1:0] A_U0 = CMD_BITS'(12'h555);
    localparam logic [CMD_BITS-1:0] A_U1 = CMD_BITS'(12'h2AA);
    localparam logic [CMD_BITS-1:0] A_QY = CMD_BITS'(12'h055);

    seq_state_t state, nxt_state;
    read_mode_t prev_mode, nxt_mode, nxt_prev;
    logic       nxt_bypass, fire, fire_chip;
    logic       at_u0, at_u1, at_qy;

    assign at_u0 = (wr_addr[CMD_BITS-1:0] == A_U0);
    assign at_u1 = (wr_addr[CMD_BITS-1:0] == A_U1);
    assign at_qy = (wr_addr[CMD_BITS-1:0] == A_QY);

    function automatic read_mode_t pop_mode(read_mode_t cur, read_mode_t prv);
        return (cur == RM_QUERY) ? prv : RM_ARRAY;
    endfunction

    always_comb begin
        nxt_state  = state;
        nxt_mode   = read_mode;
        nxt_prev   = prev_mode;
        nxt_bypass = bypass;
        fire       = 1'b0;
        fire_chip  = 1'b0;
        prog_we    = 1'b0;
        if (wr_en) begin
            nxt_state = S_IDLE;
            unique case (state)
                S_IDLE: begin
                    if (bypass) begin
                        if (wr_cmd == C_PROG)
                            nxt_state = S_PROG;
                        else if (wr_cmd == C_BYP_EXIT)
                            nxt_bypass = 1'b0;
                    end else if (wr_cmd == C_RESET) begin
                        nxt_mode = pop_mode(read_mode, prev_mode);
                    end else if (read_mode == RM_QUERY) begin
                        nxt_state = S_IDLE;
                    end else if (wr_cmd == C_QUERY && at_qy) begin
                        nxt_prev = read_mode;
                        nxt_mode = RM_QUERY;
                    end else if (wr_cmd == C_UNLK_A && at_u0) begin
                        nxt_state = S_UNLK1;
                    end
                end
                S_UNLK1: begin
                    if (wr_cmd == C_UNLK_B && at_u1)
                        nxt_state = S_UNLK2;
                    else if (wr_cmd == C_RESET)
                        nxt_mode = pop_mode(read_mode, prev_mode);
                end
                S_UNLK2: begin
                    if (at_u0 && wr_cmd == C_ID)
                        nxt_mode = RM_ID;
                    else if (at_u0 && wr_cmd == C_PROG)
                        nxt_state = S_PROG;
                    else if (at_u0 && wr_cmd == C_ERASE)
                        nxt_state = S_ESET;
                    else if (at_u0 && wr_cmd == C_BYPASS) begin
                        nxt_bypass = 1'b1;
                        nxt_mode   = RM_ARRAY;
                    end else if (wr_cmd == C_RESET)
                        nxt_mode = pop_mode(read_mode, prev_mode);
                end
                S_PROG: begin
                    prog_we = 1'b1;
                end
                S_ESET: begin
                    if (wr_cmd == C_UNLK_A && at_u0)
                        nxt_state = S_EUNLK1;
                    else if (wr_cmd == C_RESET)
                        nxt_mode = pop_mode(read_mode, prev_mode);
                end
                S_EUNLK1: begin
                    if (wr_cmd == C_UNLK_B && at_u1)
                        nxt_state = S_EUNLK2;
                    else if (wr_cmd == C_RESET)
                        nxt_mode = pop_mode(read_mode, prev_mode);
                end
                S_EUNLK2: begin
                    if (wr_cmd == C_SECTOR)
                        fire = 1'b1;
                    else if (wr_cmd == C_CHIP && at_u0) begin
                        fire      = 1'b1;
                        fire_chip = 1'b1;
                    end else if (wr_cmd == C_RESET)
                        nxt_mode = pop_mode(read_mode, prev_mode);
                end
                default: nxt_state = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt_state;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            read_mode  <= RM_ARRAY;
            prev_mode  <= RM_ARRAY;
            bypass     <= 1'b0;
            erase_req  <= 1'b0;
            erase_chip <= 1'b0;
            erase_addr <= '0;
        end else begin
            read_mode <= nxt_mode;
            prev_mode <= nxt_prev;
            bypass    <= nxt_bypass;
            erase_req <= fire;
            if (fire) begin
                erase_chip <= fire_chip;
                erase_addr <= wr_addr;
            end
        end
    end

endmodule

// File: rtl/nor_word_array.sv
module nor_word_array #(
    parameter int WORDS  = 16,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_we,
    input  logic [IDX_W-1:0]  prog_idx,
    input  logic [DATA_W-1:0] prog_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_word
);

    logic [DATA_W-1:0] cells [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n)
                cells[g] <= '1;
            else if (prog_we && prog_idx == IDX_W'(g))
                cells[g] <= cells[g] & prog_data;
        end
    end

    assign rd_word = cells[rd_idx];

endmodule

// File: rtl/nor_read_mux.sv
module nor_read_mux
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int CMD_BITS = 11
) (
    input  read_mode_t        read_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [15:0]       array_word,
    output logic [15:0]       rd_data
);

    logic [CMD_BITS-1:0] low;
    logic                unused_hi;

    assign low       = rd_addr[CMD_BITS-1:0];
    assign unused_hi = ^rd_addr;

    function automatic logic [15:0] id_word(logic [CMD_BITS-1:0] a);
        if (a == CMD_BITS'(0))      return ID_MAKER;
        else if (a == CMD_BITS'(1)) return ID_DEVICE;
        else                        return 16'h0000;
    endfunction

    function automatic logic [15:0] query_word(logic [CMD_BITS-1:0] a);
        if (a == CMD_BITS'(16))      return 16'h0051;
        else if (a == CMD_BITS'(17)) return 16'h0052;
        else if (a == CMD_BITS'(18)) return 16'h0059;
        else                         return 16'h0000;
    endfunction

    always_comb begin
        unique case (read_mode)
            RM_ARRAY: rd_data = array_word;
            RM_ID:    rd_data = id_word(low);
            RM_QUERY: rd_data = query_word(low);
            default:  rd_data = array_word;
        endcase
    end

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int ARRAY_WORDS = 16,
    parameter int CMD_BITS    = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [15:0]       rd_data,
    output logic              erase_req,
    output logic              erase_chip,
    output logic [ADDR_W-1:0] erase_addr
);

    localparam int IDX_W = $clog2(ARRAY_WORDS);

    read_mode_t  mode_w;
    logic        bypass_w;
    logic        prog_we_w;
    logic [15:0] array_word_w;

    nor_cmd_fsm #(.ADDR_W(ADDR_W), .CMD_BITS(CMD_BITS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_cmd     (wr_data[7:0]),
        .read_mode  (mode_w),
        .bypass     (bypass_w),
        .prog_we    (prog_we_w),
        .erase_req  (erase_req),
        .erase_chip (erase_chip),
        .erase_addr (erase_addr)
    );

    nor_word_array #(.WORDS(ARRAY_WORDS), .DATA_W(16)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_we   (prog_we_w),
        .prog_idx  (wr_addr[IDX_W-1:0]),
        .prog_data (wr_data),
        .rd_idx    (rd_addr[IDX_W-1:0]),
        .rd_word   (array_word_w)
    );

    nor_read_mux #(.ADDR_W(ADDR_W), .CMD_BITS(CMD_BITS)) u_mux (
        .read_mode  (mode_w),
        .rd_addr    (rd_addr),
        .array_word (array_word_w),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int CMD_BITS = 11
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [CMD_BITS-1:0] wr_low,
    input logic [7:0]          wr_cmd,
    input logic [ADDR_W-1:0]   rd_addr,
    input logic [15:0]         rd_data,
    input read_mode_t          read_mode,
    input logic                bypass,
    input logic                erase_req,
    input logic                erase_chip
);

    // R4
    array_only_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (read_mode == RM_ARRAY && $past(read_mode) == RM_ARRAY && $stable(rd_addr))
        |-> ((rd_data & ~$past(rd_data)) == 16'h0000));

    // R7
    query_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(read_mode == RM_QUERY) |-> ($past(wr_en) && $past(wr_cmd) == C_QUERY));

    // R5
    bypass_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bypass) |-> ($past(wr_en) && $past(wr_cmd) == C_BYPASS));

    // R6
    bypass_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bypass) |-> ($past(wr_en) && $past(wr_cmd) == C_BYP_EXIT));

    // R10
    erase_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> $past(wr_en));

    // R11
    chip_erase_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && erase_chip) |->
        ($past(wr_cmd) == C_CHIP && $past(wr_low) == CMD_BITS'(12'h555)));

    // R12
    erase_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |=> !erase_req);

endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.ADDR_W(ADDR_W), .CMD_BITS(CMD_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_low     (wr_addr[CMD_BITS-1:0]),
    .wr_cmd     (wr_data[7:0]),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .read_mode  (mode_w),
    .bypass     (bypass_w),
    .erase_req  (erase_req),
    .erase_chip (erase_chip)
);

// File: tb/nor_cmd_seq_test.sv
module nor_cmd_seq_test;

    localparam int AW = 16;
    localparam int NV = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [15:0]   rd_data;
    logic          erase_req, erase_chip;
    logic [AW-1:0] erase_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    nor_cmd_seq uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .erase_req(erase_req), .erase_chip(erase_chip), .erase_addr(erase_addr)
    );

    // {read, requirement, address, data or expected}
    localparam logic [36:0] VEC [NV] = '{
        {1'b0, 4'd2, 16'h0555, 16'h00AA},  // R2
        {1'b0, 4'd2, 16'h02AA, 16'h0055},
        {1'b0, 4'd2, 16'h0555, 16'h0090},
        {1'b1, 4'd2, 16'h0000, 16'h00BF},
        {1'b1, 4'd2, 16'h0001, 16'h236D},
        {1'b1, 4'd2, 16'h0002, 16'h0000},
        {1'b0, 4'd8, 16'h0000, 16'h00F0},  // R8
        {1'b1, 4'd8, 16'h0000, 16'hFFFF},
        {1'b0, 4'd4, 16'h0555, 16'h00AA},  // R4
        {1'b0, 4'd4, 16'h02AA, 16'h0055},
        {1'b0, 4'd4, 16'h0555, 16'h00A0},
        {1'b0, 4'd4, 16'h0003, 16'h0055},
        {1'b1, 4'd4, 16'h0003, 16'h0055},
        {1'b0, 4'd4, 16'h0555, 16'h00AA},
        {1'b0, 4'd4, 16'h02AA, 16'h0055},
        {1'b0, 4'd4, 16'h0555, 16'h00A0},
        {1'b0, 4'd4, 16'h0003, 16'h00A5},
        {1'b1, 4'd4, 16'h0003, 16'h0005},
        {1'b0, 4'd3, 16'h5555, 16'h00AA},  // R3
        {1'b0, 4'd3, 16'h2AAA, 16'h0055},
        {1'b0, 4'd3, 16'h5555, 16'h0090},
        {1'b1, 4'd3, 16'h0000, 16'h00BF},
        {1'b0, 4'd7, 16'h0055, 16'h0098},  // R7
        {1'b1, 4'd7, 16'h0010, 16'h0051},
        {1'b1, 4'd7, 16'h0011, 16'h0052},
        {1'b1, 4'd7, 16'h0012, 16'h0059},
        {1'b0, 4'd8, 16'h0000, 16'h00F0},  // R8 back to id
        {1'b1, 4'd8, 16'h0000, 16'h00BF},
        {1'b0, 4'd8, 16'h0000, 16'h00F0},
        {1'b1, 4'd8, 16'h0003, 16'h0005},
        {1'b0, 4'd7, 16'h0055, 16'h0098},
        {1'b1, 4'd7, 16'h0010, 16'h0051},
        {1'b0, 4'd8, 16'h0123, 16'h00F0},
        {1'b1, 4'd8, 16'h0003, 16'h0005},
        {1'b0, 4'd5, 16'h0555, 16'h00AA},  // R5
        {1'b0, 4'd5, 16'h02AA, 16'h0055},
        {1'b0, 4'd5, 16'h0555, 16'h0020},
        {1'b0, 4'd5, 16'h0007, 16'h00A0},
        {1'b0, 4'd5, 16'h0007, 16'h1234},
        {1'b1, 4'd5, 16'h0007, 16'h1234},
        {1'b0, 4'd5, 16'h0009, 16'h00A0},
        {1'b0, 4'd5, 16'h0009, 16'hABCD},
        {1'b1, 4'd5, 16'h0009, 16'hABCD},
        {1'b0, 4'd6, 16'h0000, 16'h0000},  // R6
        {1'b0, 4'd6, 16'h0004, 16'h00A0},
        {1'b0, 4'd6, 16'h0004, 16'h0000},
        {1'b1, 4'd6, 16'h0004, 16'hFFFF},
        {1'b0, 4'd9, 16'h0555, 16'h00AA},  // R9
        {1'b0, 4'd9, 16'h02AA, 16'h0055},
        {1'b0, 4'd9, 16'h0123, 16'h00A0},
        {1'b0, 4'd9, 16'h0005, 16'h0000},
        {1'b1, 4'd9, 16'h0005, 16'hFFFF},
        {1'b0, 4'd9, 16'h0555, 16'h00AA},
        {1'b0, 4'd9, 16'h02AA, 16'h0012},
        {1'b0, 4'd9, 16'h0555, 16'h00A0},
        {1'b0, 4'd9, 16'h0006, 16'h0000},
        {1'b1, 4'd9, 16'h0006, 16'hFFFF},
        {1'b0, 4'd9, 16'h0555, 16'h00AA},
        {1'b0, 4'd9, 16'h02AA, 16'h0055},
        {1'b0, 4'd9, 16'h0555, 16'h0090},
        {1'b0, 4'd9, 16'h0555, 16'h00AA},
        {1'b0, 4'd9, 16'h0000, 16'h0033},
        {1'b1, 4'd9, 16'h0001, 16'h236D},
        {1'b0, 4'd8, 16'h0000, 16'h00F0}
    };

    task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input int req, input logic [AW-1:0] a, input logic [15:0] exp);
        rd_addr = a;
        #2;
        check(req, {16'h0, rd_data}, {16'h0, exp});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic erase_prefix();
        bus_write(16'h0555, 16'h00AA);
        bus_write(16'h02AA, 16'h0055);
        bus_write(16'h0555, 16'h0080);
        bus_write(16'h0555, 16'h00AA);
        bus_write(16'h02AA, 16'h0055);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 190000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset state
        bus_read(1, 16'h0000, 16'hFFFF);
        bus_read(1, 16'h000F, 16'hFFFF);
        check(1, {31'h0, erase_req}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][36])
                bus_read(int'(VEC[i][35:32]), VEC[i][31:16], VEC[i][15:0]);
            else
                bus_write(VEC[i][31:16], VEC[i][15:0]);
        end

        // R10 sector erase request
        erase_prefix();
        check(10, {31'h0, erase_req}, 32'h0);
        bus_write(16'h0040, 16'h0030);
        check(10, {31'h0, erase_req}, 32'h1);
        check(10, {31'h0, erase_chip}, 32'h0);
        check(10, {16'h0, erase_addr}, {16'h0, 16'h0040});
        @(negedge clk);
        check(12, {31'h0, erase_req}, 32'h0);

        // R11 chip erase request
        erase_prefix();
        bus_write(16'h0555, 16'h0010);
        check(11, {31'h0, erase_req}, 32'h1);
        check(11, {31'h0, erase_chip}, 32'h1);
        @(negedge clk);
        check(12, {31'h0, erase_req}, 32'h0);

        // R12 wrong final write raises nothing
        erase_prefix();
        bus_write(16'h0040, 16'h0077);
        check(12, {31'h0, erase_req}, 32'h0);
        @(negedge clk);
        check(12, {31'h0, erase_req}, 32'h0);
        bus_read(12, 16'h0003, 16'h0005);

        // R1 reset mid-sequence forgets the unlock writes
        bus_write(16'h0555, 16'h00AA);
        bus_write(16'h02AA, 16'h0055);
        do_reset();
        bus_write(16'h0555, 16'h0090);
        bus_read(1, 16'h0000, 16'hFFFF);
        bus_read(1, 16'h0003, 16'hFFFF);

        // R1 reset clears bypass mode
        bus_write(16'h0555, 16'h00AA);
        bus_write(16'h02AA, 16'h0055);
        bus_write(16'h0555, 16'h0020);
        do_reset();
        bus_write(16'h0004, 16'h00A0);
        bus_write(16'h0004, 16'h0000);
        bus_read(1, 16'h0004, 16'hFFFF);

        finish_run();
    end

endmodule